// File: doc/BRIEF.md
# Ethernet DMA Control Register File

This block is the memory-mapped control and status front end of an Ethernet DMA engine that serves up to eight transmit rings and eight receive rings. A host reaches it through a simple 32-bit word port. The port has separate read and write strobes, a byte address inside a 4 KB window, and a read result that is registered. The block keeps an interrupt event register and an interrupt mask register. Three level interrupt lines, one each for the transmit, receive and error groups, are derived from those two registers.

The block also keeps per-ring halt flags for transmit and receive, a base address and a current-pointer register for every ring, a DMA control word and a poll-rate divider. Writes to these registers have side effects, and the side effects become single-cycle pulses toward the DMA engine:
- Clearing a halt flag kicks the matching ring.
- Writing a ring base loads that ring's pointer.
- A graceful stop request completes at once, or it completes when the frame in flight ends.
- A prescaled poll tick kicks transmit ring 0 while polling is enabled.

The data path reports three kinds of input: frames in progress, halt conditions and event conditions. Hardware sets always win over a software clear in the same cycle.

Top module: `eth_dma_csr`

## Requirements
- R1: After reset every output is 0. The following registers read as shown:
  - event register (0x000): 0
  - mask register (0x004): 0
  - DMA control (0x008): 0x0000_0004. Bit 0 is the transmit graceful stop, bit 1 is the receive graceful stop, and bit 2 disables polling.
  - transmit status (0x00C): 0
  - receive status (0x010): 0
  - all ring base and pointer registers: 0
- R2: Writing the event register clears each bit written as 1 and leaves bits written as 0 unchanged. A bit raised on `evt_set` in the same cycle stays set. Reads of the event register return its current value.
- R3: The three interrupt lines are grouped over the bits of (event AND mask):
  - `irq_tx` is high when any of bits [7:0] are set.
  - `irq_rx` is high when any of bits [15:8] are set.
  - `irq_err` is high when any of bits [31:16] are set.
  - Each line follows the registers with no added cycle.
- R4: Writing 1 to transmit status bit (31-i) pulses `tx_kick[i]` for one cycle, starting on the cycle after the write, whatever that bit held before. Every bit written as 1 is then cleared. `tx_halt_set[i]` sets bit (31-i). Bits outside [31:24] read 0.
- R5: Writing 1 to receive status bit (23-i) pulses `rx_kick[i]` only if that bit was already 0 before the write. Every bit written as 1 is then cleared. `rx_halt_set[i]` sets bit (23-i). Bits outside [23:16] read 0.
- R6: A write to transmit ring base i (0x100+4i) or receive ring base i (0x180+4i) stores the value with bits [2:0] forced to 0. The same value is copied into that ring's pointer (transmit 0x140+4i, receive 0x1C0+4i). Pointer locations are read-only.
- R7: Writing DMA control with bit 0 set while `tx_busy` is 0 sets event bit 1 on the next cycle. Writing it with bit 1 set while `rx_busy` is 0 sets event bit 9.
- R8: If the matching busy input is 1 when the stop is written, the event bit is set on the cycle after that busy input falls, and only if the stop bit is still set at that time. Clearing the stop bit first cancels the request.
- R9: While DMA control bit 2 is 0, `poll_tick` pulses once every (D+1) cycles. D is the divider value, which resets to 4. The first pulse comes D+1 cycles after any DMA control write with bit 2 equal to 0, because such a write restarts the count. Each tick also pulses `tx_kick[0]`, unless DMA control bit 0 is set.
- R10: The divider (0x014) is write-only and reads 0. Unknown locations read 0 and ignore writes. An access whose address bits [1:0] are not 0 is ignored.
- R11: `bus_rdata` shows the addressed register on the cycle after `bus_rd`, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_busy | input | 1 | Receive frame in progress |
| evt_set | input | 32 | Hardware event set pulses |
| tx_halt_set | input | NRING | Transmit ring halt set pulses |
| rx_halt_set | input | NRING | Receive ring halt set pulses |
| irq_tx | output | 1 | Transmit group interrupt |
| irq_rx | output | 1 | Receive group interrupt |
| irq_err | output | 1 | Error group interrupt |
| tx_kick | output | NRING | Transmit ring kick pulses |
| rx_kick | output | NRING | Receive ring kick pulses |
| poll_tick | output | 1 | Poll prescaler tick |

## Verification
The checker watches a set of rules on every cycle:
- A kick on a receive ring, or on a transmit ring above 0, must follow a write to its status register.
- A kick on transmit ring 0 must come from either a poll tick or a status write.
- A poll tick needs polling to have been enabled on the cycle before.
- Writing an all-zero mask drops all three interrupt lines.

Several behaviours need whole sequences and are shown only by the bench's sweeps:
- interrupt grouping, swept over all 32 event bits
- the receive kick rule that depends on the old flag value
- base-to-pointer copying with masking, across every ring
- deferred and cancelled graceful stops
- the exact poll period after a restart

// File: rtl/ethcsr_pkg.sv
package ethcsr_pkg;
    // DMA control bit positions
    localparam int CTL_TX_STOP = 0;
    localparam int CTL_RX_STOP = 1;
    localparam int CTL_NOPOLL  = 2;
    localparam logic [31:0] CTL_RESET = 32'h0000_0004;

    // event bits raised by graceful stop completion
    localparam int EVT_TX_STOPPED = 1;
    localparam int EVT_RX_STOPPED = 9;

    // interrupt groups
    localparam logic [31:0] GRP_TX  = 32'h0000_00FF;
    localparam logic [31:0] GRP_RX  = 32'h0000_FF00;
    localparam logic [31:0] GRP_ERR = 32'hFFFF_0000;

    // word indices of scalar registers
    localparam int W_EVT  = 0;
    localparam int W_MSK  = 1;
    localparam int W_CTL  = 2;
    localparam int W_TST  = 3;
    localparam int W_RST  = 4;
    localparam int W_DIV  = 5;

    // 16-word blocks holding per-ring registers
    localparam int B_TXBASE = 4;
    localparam int B_TXPTR  = 5;
    localparam int B_RXBASE = 6;
    localparam int B_RXPTR  = 7;
endpackage

// File: rtl/ethcsr_halt.sv
module ethcsr_halt #(
    parameter int NRING = 8,
    parameter bit KICK_ONLY_IF_CLEAR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [NRING-1:0] field,
    input  logic [NRING-1:0] set,
    output logic [NRING-1:0] stat_q,
    output logic [NRING-1:0] kick_q
);
    logic [NRING-1:0] gate;
    logic [NRING-1:0] stat_d;
    logic [NRING-1:0] kick_d;

    generate
        if (KICK_ONLY_IF_CLEAR) begin : g_edge
            assign gate = ~stat_q;
        end else begin : g_level
            assign gate = '1;
        end
    endgenerate

    always_comb begin
        kick_d = wr ? (field & gate) : '0;
        stat_d = (stat_q & ~(wr ? field : '0)) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            kick_q <= '0;
        end else begin
            stat_q <= stat_d;
            kick_q <= kick_d;
        end
    end
endmodule

// File: rtl/ethcsr_rings.sv
module ethcsr_rings #(
    parameter int NRING = 8,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRING-1:0]          wr_sel,
    input  logic [DW-1:0]             wdata,
    output logic [NRING-1:0][DW-1:0]  base_o,
    output logic [NRING-1:0][DW-1:0]  ptr_o
);
    localparam int ALIGN = 3;

    logic [DW-1:0] aligned;
    assign aligned = {wdata[DW-1:ALIGN], {ALIGN{1'b0}}};

    for (genvar r = 0; r < NRING; r++) begin : g_ring
        logic [DW-1:0] base_d, base_q, ptr_d, ptr_q;

        always_comb begin
            base_d = base_q;
            ptr_d  = ptr_q;
            if (wr_sel[r]) begin
                base_d = aligned;
                ptr_d  = aligned;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                ptr_q  <= '0;
            end else begin
                base_q <= base_d;
                ptr_q  <= ptr_d;
            end
        end

        assign base_o[r] = base_q;
        assign ptr_o[r]  = ptr_q;
    end
endmodule

// File: rtl/ethcsr_poll.sv
module ethcsr_poll #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick_q
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         tick_d;

    always_comb begin
        tick_d = 1'b0;
        cnt_d  = cnt_q;
        if (restart || !en) begin
            cnt_d = '0;
        end else if (cnt_q == div) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end
endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
    import ethcsr_pkg::*;
#(
    parameter int NRING        = 8,
    parameter int ADDR_W       = 12,
    parameter int POLL_W       = 16,
    parameter int POLL_DIV_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic [31:0]       evt_set,
    input  logic [NRING-1:0]  tx_halt_set,
    input  logic [NRING-1:0]  rx_halt_set,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err,
    output logic [NRING-1:0]  tx_kick,
    output logic [NRING-1:0]  rx_kick,
    output logic              poll_tick
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int BLK_W = IDX_W - 4;

    typedef struct packed {
        logic [31:0]       evt;
        logic [31:0]       msk;
        logic [31:0]       ctl;
        logic [POLL_W-1:0] div;
        logic [31:0]       rdata;
        logic              txb;
        logic              rxb;
        logic              tx_pend;
        logic              rx_pend;
    } state_t;

    state_t s_d, s_q;
    logic [31:0] ctl_q;
    assign ctl_q = s_q.ctl;

    // address decode
    logic [IDX_W-1:0] idx;
    logic [BLK_W-1:0] blk;
    logic [3:0]       slot;
    logic             aligned_ok, wr_ok, rd_ok;
    logic             hit_evt, hit_msk, hit_ctl, hit_tst, hit_rst, hit_div;
    logic [NRING-1:0] txb_sel, rxb_sel;

    assign idx        = bus_addr[ADDR_W-1:2];
    assign blk        = idx[IDX_W-1:4];
    assign slot       = idx[3:0];
    assign aligned_ok = (bus_addr[1:0] == 2'b00);
    assign wr_ok      = bus_wr && aligned_ok;
    assign rd_ok      = bus_rd && aligned_ok;

    assign hit_evt = wr_ok && (idx == IDX_W'(W_EVT));
    assign hit_msk = wr_ok && (idx == IDX_W'(W_MSK));
    assign hit_ctl = wr_ok && (idx == IDX_W'(W_CTL));
    assign hit_tst = wr_ok && (idx == IDX_W'(W_TST));
    assign hit_rst = wr_ok && (idx == IDX_W'(W_RST));
    assign hit_div = wr_ok && (idx == IDX_W'(W_DIV));

    always_comb begin
        for (int i = 0; i < NRING; i++) begin
            txb_sel[i] = wr_ok && (blk == BLK_W'(B_TXBASE)) && (slot == 4'(i));
            rxb_sel[i] = wr_ok && (blk == BLK_W'(B_RXBASE)) && (slot == 4'(i));
        end
    end

    // halt status fields: tx ring i at bit 31-i, rx ring i at bit 23-i
    logic [NRING-1:0] tx_field, rx_field, tx_stat, rx_stat, tx_kick_st, rx_kick_st;
    logic [31:0]      tx_word, rx_word;

    always_comb begin
        tx_word = '0;
        rx_word = '0;
        for (int i = 0; i < NRING; i++) begin
            tx_field[i]     = bus_wdata[31-i];
            rx_field[i]     = bus_wdata[23-i];
            tx_word[31-i]   = tx_stat[i];
            rx_word[23-i]   = rx_stat[i];
        end
    end

    ethcsr_halt #(.NRING(NRING), .KICK_ONLY_IF_CLEAR(1'b0)) tx_halt_i (
        .clk(clk), .rst_n(rst_n), .wr(hit_tst), .field(tx_field),
        .set(tx_halt_set), .stat_q(tx_stat), .kick_q(tx_kick_st)
    );

    ethcsr_halt #(.NRING(NRING), .KICK_ONLY_IF_CLEAR(1'b1)) rx_halt_i (
        .clk(clk), .rst_n(rst_n), .wr(hit_rst), .field(rx_field),
        .set(rx_halt_set), .stat_q(rx_stat), .kick_q(rx_kick_st)
    );

    logic [NRING-1:0][31:0] tx_base, tx_ptr, rx_base, rx_ptr;

    ethcsr_rings #(.NRING(NRING), .DW(32)) tx_rings_i (
        .clk(clk), .rst_n(rst_n), .wr_sel(txb_sel), .wdata(bus_wdata),
        .base_o(tx_base), .ptr_o(tx_ptr)
    );

    ethcsr_rings #(.NRING(NRING), .DW(32)) rx_rings_i (
        .clk(clk), .rst_n(rst_n), .wr_sel(rxb_sel), .wdata(bus_wdata),
        .base_o(rx_base), .ptr_o(rx_ptr)
    );

    ethcsr_poll #(.W(POLL_W)) poll_i (
        .clk(clk), .rst_n(rst_n),
        .en(!s_q.ctl[CTL_NOPOLL]),
        .restart(hit_ctl && !bus_wdata[CTL_NOPOLL]),
        .div(s_q.div),
        .tick_q(poll_tick)
    );

    // read mux
    logic [31:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (idx == IDX_W'(W_EVT))      rd_val = s_q.evt;
        else if (idx == IDX_W'(W_MSK)) rd_val = s_q.msk;
        else if (idx == IDX_W'(W_CTL)) rd_val = s_q.ctl;
        else if (idx == IDX_W'(W_TST)) rd_val = tx_word;
        else if (idx == IDX_W'(W_RST)) rd_val = rx_word;
        else begin
            for (int i = 0; i < NRING; i++) begin
                if (slot == 4'(i)) begin
                    if (blk == BLK_W'(B_TXBASE)) rd_val = tx_base[i];
                    if (blk == BLK_W'(B_TXPTR))  rd_val = tx_ptr[i];
                    if (blk == BLK_W'(B_RXBASE)) rd_val = rx_base[i];
                    if (blk == BLK_W'(B_RXPTR))  rd_val = rx_ptr[i];
                end
            end
        end
    end

    // next state
    always_comb begin
        logic [31:0] done;
        s_d     = s_q;
        done    = '0;
        s_d.txb = tx_busy;
        s_d.rxb = rx_busy;

        if (hit_msk) s_d.msk = bus_wdata;
        if (hit_div) s_d.div = bus_wdata[POLL_W-1:0];
        if (rd_ok)   s_d.rdata = rd_val;

        // transmit graceful stop
        if (hit_ctl) begin
            s_d.tx_pend = bus_wdata[CTL_TX_STOP] && tx_busy;
            if (bus_wdata[CTL_TX_STOP] && !tx_busy) done[EVT_TX_STOPPED] = 1'b1;
        end else if (s_q.tx_pend) begin
            if (!s_q.ctl[CTL_TX_STOP]) begin
                s_d.tx_pend = 1'b0;
            end else if (s_q.txb && !tx_busy) begin
                s_d.tx_pend = 1'b0;
                done[EVT_TX_STOPPED] = 1'b1;
            end
        end

        // receive graceful stop
        if (hit_ctl) begin
            s_d.rx_pend = bus_wdata[CTL_RX_STOP] && rx_busy;
            if (bus_wdata[CTL_RX_STOP] && !rx_busy) done[EVT_RX_STOPPED] = 1'b1;
        end else if (s_q.rx_pend) begin
            if (!s_q.ctl[CTL_RX_STOP]) begin
                s_d.rx_pend = 1'b0;
            end else if (s_q.rxb && !rx_busy) begin
                s_d.rx_pend = 1'b0;
                done[EVT_RX_STOPPED] = 1'b1;
            end
        end

        if (hit_ctl) s_d.ctl = bus_wdata;

        s_d.evt = (s_q.evt & ~(hit_evt ? bus_wdata : 32'h0)) | evt_set | done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.ctl     <= CTL_RESET;
            s_q.div     <= POLL_W'(POLL_DIV_RST);
        end else begin
            s_q <= s_d;
        end
    end

    // outputs
    logic [31:0] active;
    assign active    = s_q.evt & s_q.msk;
    assign irq_tx    = |(active & GRP_TX);
    assign irq_rx    = |(active & GRP_RX);
    assign irq_err   = |(active & GRP_ERR);
    assign bus_rdata = s_q.rdata;
    assign rx_kick   = rx_kick_st;
    assign tx_kick   = tx_kick_st
                     | NRING'(poll_tick && !s_q.ctl[CTL_TX_STOP]);
endmodule

// File: rtl/eth_dma_csr_chk.sv
module eth_dma_csr_chk
    import ethcsr_pkg::*;
#(
    parameter int NRING  = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NRING-1:0]  tx_kick,
    input logic [NRING-1:0]  rx_kick,
    input logic              poll_tick,
    input logic              irq_tx,
    input logic              irq_rx,
    input logic              irq_err,
    input logic [31:0]       ctl_q
);
    logic wr_tst, wr_rst, wr_msk0;
    assign wr_tst  = bus_wr && bus_addr == ADDR_W'(W_TST * 4);
    assign wr_rst  = bus_wr && bus_addr == ADDR_W'(W_RST * 4);
    assign wr_msk0 = bus_wr && bus_addr == ADDR_W'(W_MSK * 4) && bus_wdata == 32'h0;

    // R4
    tx_kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_kick >> 1)) |-> $past(wr_tst));

    // R4
    tx_kick0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick[0] |-> (poll_tick || $past(wr_tst)));

    // R5
    rx_kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_kick) |-> $past(wr_rst));

    // R9
    poll_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_tick |-> $past(!ctl_q[CTL_NOPOLL]));

    // R3
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_msk0 |=> (!irq_tx && !irq_rx && !irq_err));
endmodule

bind eth_dma_csr eth_dma_csr_chk #(.NRING(NRING), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tx_kick(tx_kick), .rx_kick(rx_kick),
    .poll_tick(poll_tick), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_err(irq_err), .ctl_q(ctl_q)
);

// File: tb/eth_dma_csr_tb_top.sv
module eth_dma_csr_tb_top;
    localparam int CLK_P = 10;
    localparam int NR    = 8;

    localparam logic [11:0] A_EVT = 12'h000;
    localparam logic [11:0] A_MSK = 12'h004;
    localparam logic [11:0] A_CTL = 12'h008;
    localparam logic [11:0] A_TST = 12'h00C;
    localparam logic [11:0] A_RST = 12'h010;
    localparam logic [11:0] A_DIV = 12'h014;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic tx_busy = 1'b0, rx_busy = 1'b0;
    logic [31:0] evt_set = '0;
    logic [NR-1:0] tx_halt_set = '0, rx_halt_set = '0;
    logic irq_tx, irq_rx, irq_err, poll_tick;
    logic [NR-1:0] tx_kick, rx_kick;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #(CLK_P/2) clk = ~clk;

    eth_dma_csr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .evt_set(evt_set),
        .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
        .tx_kick(tx_kick), .rx_kick(rx_kick), .poll_tick(poll_tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] bit_v;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 outputs", {irq_tx, irq_rx, irq_err, poll_tick, tx_kick, rx_kick}, '0);
        rd(A_EVT, v); chk("R1 evt", v, 32'h0);
        rd(A_MSK, v); chk("R1 msk", v, 32'h0);
        rd(A_CTL, v); chk("R1 ctl", v, 32'h4);
        rd(A_TST, v); chk("R1 tst", v, 32'h0);
        rd(A_RST, v); chk("R1 rst", v, 32'h0);
        rd(12'h104, v); chk("R1 txbase", v, 32'h0);
        rd(12'h1C4, v); chk("R1 rxptr", v, 32'h0);

        // R2 write-one-to-clear and set priority
        evt_set = 32'hFFFF_FFFF; step(); evt_set = '0;
        wr(A_EVT, 32'h0F0F_0F0F);
        rd(A_EVT, v); chk("R2 w1c", v, 32'hF0F0_F0F0);
        bus_wr = 1'b1; bus_addr = A_EVT; bus_wdata = 32'hFFFF_FFFF; evt_set = 32'h0000_0010;
        step();
        bus_wr = 1'b0; evt_set = '0;
        rd(A_EVT, v); chk("R2 set wins", v, 32'h0000_0010);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, v); chk("R2 cleared", v, 32'h0);
        // R11 read data holds until next read
        step(); step();
        chk("R11 hold", bus_rdata, 32'h0);

        // R3 grouping sweep over every event bit
        for (int b = 0; b < 32; b++) begin
            bit_v = 32'h1 << b;
            wr(A_MSK, ~bit_v);
            evt_set = bit_v; step(); evt_set = '0;
            chk("R3 other mask quiet", {29'h0, irq_tx, irq_rx, irq_err}, 32'h0);
            wr(A_MSK, bit_v);
            chk("R3 group", {29'h0, irq_tx, irq_rx, irq_err},
                {29'h0, b < 8, (b >= 8 && b < 16), b >= 16});
            wr(A_MSK, 32'h0);
            chk("R3 mask zero", {29'h0, irq_tx, irq_rx, irq_err}, 32'h0);
            wr(A_EVT, bit_v);
        end

        // R4 transmit status sweep
        for (int i = 0; i < NR; i++) begin
            tx_halt_set = NR'(1) << i; step(); tx_halt_set = '0;
            rd(A_TST, v); chk("R4 halt set", v, 32'h8000_0000 >> i);
            wr(A_TST, 32'h8000_0000 >> i);
            chk("R4 kick", {24'h0, tx_kick}, 32'h1 << i);
            step();
            chk("R4 kick pulse", {24'h0, tx_kick}, 32'h0);
            rd(A_TST, v); chk("R4 cleared", v, 32'h0);
        end
        wr(A_TST, 32'hFF00_FFFF);
        chk("R4 kick all from zero", {24'h0, tx_kick}, 32'hFF);
        rd(A_TST, v); chk("R4 other bits", v, 32'h0);

        // R5 receive status: kick only rings whose flag was clear
        for (int i = 0; i < NR; i++) begin
            rx_halt_set = NR'(1) << i; step(); rx_halt_set = '0;
            rd(A_RST, v); chk("R5 halt set", v, 32'h0080_0000 >> i);
            wr(A_RST, (32'h0080_0000 >> i) | (32'h0080_0000 >> ((i + 1) % NR)));
            chk("R5 kick", {24'h0, rx_kick}, 32'h1 << ((i + 1) % NR));
            rd(A_RST, v); chk("R5 cleared", v, 32'h0);
        end

        // R6 ring bases and pointers
        for (int i = 0; i < NR; i++) begin
            v = 32'hA5C3_0007 + (i << 8);
            wr(12'h100 + 12'(4 * i), v);
            wr(12'h180 + 12'(4 * i), ~v);
            wr(12'h140 + 12'(4 * i), 32'h1111_1110);
            rd(12'h100 + 12'(4 * i), bit_v); chk("R6 txbase", bit_v, v & ~32'h7);
            rd(12'h140 + 12'(4 * i), bit_v); chk("R6 txptr", bit_v, v & ~32'h7);
            rd(12'h180 + 12'(4 * i), bit_v); chk("R6 rxbase", bit_v, ~v & ~32'h7);
            rd(12'h1C0 + 12'(4 * i), bit_v); chk("R6 rxptr", bit_v, ~v & ~32'h7);
        end

        // R10 write-only, unknown, misaligned
        wr(A_DIV, 32'h3);
        rd(A_DIV, v); chk("R10 wo reads zero", v, 32'h0);
        wr(12'h800, 32'hDEAD_BEEF);
        rd(12'h800, v); chk("R10 unknown", v, 32'h0);
        wr(12'h006, 32'h1234_5678);
        rd(A_MSK, v); chk("R10 misaligned", v, 32'h0);

        // R9 poll period with divider 3
        wr(A_CTL, 32'h0);
        for (int k = 1; k <= 8; k++) begin
            step();
            chk("R9 tick", {31'h0, poll_tick}, {31'h0, (k % 4) == 0});
            chk("R9 poll kick", {24'h0, tx_kick}, ((k % 4) == 0) ? 32'h1 : 32'h0);
        end
        wr(A_CTL, 32'h1);
        for (int k = 1; k <= 8; k++) begin
            step();
            chk("R9 tick stopped tx", {31'h0, poll_tick}, {31'h0, (k % 4) == 0});
            chk("R9 no kick under stop", {24'h0, tx_kick}, 32'h0);
        end
        wr(A_CTL, 32'h4);
        for (int k = 1; k <= 10; k++) begin
            step();
            chk("R9 polling off", {31'h0, poll_tick}, 32'h0);
        end

        // R7 immediate graceful stops
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_CTL, 32'h7);
        rd(A_EVT, v); chk("R7 immediate", v, 32'h0000_0202);

        // R8 deferred transmit stop
        wr(A_CTL, 32'h4); wr(A_EVT, 32'hFFFF_FFFF);
        tx_busy = 1'b1;
        wr(A_CTL, 32'h5);
        step(); step();
        rd(A_EVT, v); chk("R8 wait for frame", v, 32'h0);
        tx_busy = 1'b0;
        step();
        rd(A_EVT, v); chk("R8 tx deferred", v, 32'h2);

        // R8 deferred receive stop
        wr(A_CTL, 32'h4); wr(A_EVT, 32'hFFFF_FFFF);
        rx_busy = 1'b1;
        wr(A_CTL, 32'h6);
        step();
        rd(A_EVT, v); chk("R8 rx waiting", v, 32'h0);
        rx_busy = 1'b0;
        step();
        rd(A_EVT, v); chk("R8 rx deferred", v, 32'h200);

        // R8 cancelled request
        wr(A_CTL, 32'h4); wr(A_EVT, 32'hFFFF_FFFF);
        tx_busy = 1'b1;
        wr(A_CTL, 32'h5);
        wr(A_CTL, 32'h4);
        tx_busy = 1'b0;
        step(); step();
        rd(A_EVT, v); chk("R8 cancelled", v, 32'h0);

        finish_run();
    end
endmodule